// File: doc/BRIEF.md
# Branch-Free Predicated Selection Scanner

This block scans a stream of tuples. Each tuple carries a sequence index and a set of attribute fields. For every tuple it evaluates a conjunction of up to `NPRED` strict less-than tests. Each test compares one field against a programmable threshold. From the results it builds a compacted list of the indices that qualify. The list is written through a simple memory write port, and a live count of matches is kept alongside it.

No control decision depends on the data. The block writes the index of every accepted tuple to the slot at the current write pointer, whether the tuple qualifies or not. It then advances the pointer and the count by the single result bit. A slot that was filled by a non-qualifying tuple is taken over by the next tuple, so every tuple costs one cycle whatever the selectivity. All enabled terms are evaluated side by side and ANDed together; there is no early exit on a false term.

In the optional dual-lane mode the index range is split at a programmable point. The lower part and the upper part each have a private pointer and a private counter, and each lane writes its own region of the output memory. When a tuple flagged as final passes through, the block pulses a done strobe carrying the sum of the two counters, then clears its pointers so that the next scan can follow with no gap.

Top module: `sel_scan_top`

## Requirements
- R1: Reset, whether at power-up or in the middle of a scan, clears both write pointers and both counters to zero. While reset is held, `done` and `wr_en` are low and `match_cnt` is zero.
- R2: A tuple qualifies only if every enabled term holds, where term i holds when field i (bits i*FW and up of `in_fields`) is strictly less than threshold i (same slice of `thr_vec`). A field equal to its threshold fails.
- R3: A term whose bit in `pred_en` is 0 is treated as true. With every bit of `pred_en` at 0, every tuple qualifies.
- R4: Each accepted tuple drives `wr_en` high in the cycle after acceptance, with `wr_data` equal to its index and `wr_addr` equal to its lane's base plus that lane's pointer. This holds whether or not the tuple qualifies.
- R5: A lane's pointer and the live `match_cnt` grow by exactly the tuple's 1-bit result one clock after the write cycle begins. A cycle with no accepted tuple writes nothing and leaves `match_cnt` unchanged.
- R6: `in_ready` is low during reset and high from the first clock after reset on. One tuple is accepted per cycle with no bubbles.
- R7: When a tuple with `in_last` set is accepted, `done` goes high for exactly one cycle, one clock after that tuple's write cycle. `done_cnt` then holds the scan's total count, including that tuple. In the same cycle the pointers and counters read zero.
- R8: With `dual_mode` at 1, a tuple whose index is at or above `split_idx` uses the upper lane. The upper lane's base address is half the slot count; the lower lane's base is 0. Each lane has its own pointer and counter, and `done_cnt` is their sum. With `dual_mode` at 0, every tuple uses the lower lane.
- R9: After a single-lane scan, slots 0 to `done_cnt`-1 hold the qualifying indices in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | 1 = split the index range into two lanes |
| split_idx | input | IW | First index that belongs to the upper lane |
| pred_en | input | NPRED | Per-term enable |
| thr_vec | input | NPRED*FW | Per-term thresholds, term i at bits i*FW |
| in_valid | input | 1 | Tuple present |
| in_ready | output | 1 | Block can accept a tuple |
| in_idx | input | IW | Tuple sequence index |
| in_fields | input | NPRED*FW | Tuple attribute fields, field i at bits i*FW |
| in_last | input | 1 | Final tuple of the scan |
| wr_en | output | 1 | Output memory write strobe |
| wr_addr | output | AW | Output memory slot |
| wr_data | output | IW | Index written to the slot |
| match_cnt | output | CW | Live sum of the lane counters |
| done | output | 1 | One-cycle end-of-scan pulse |
| done_cnt | output | CW | Final match count, valid with done |

## Verification
The hardest situation to reach is overlap. The write for a non-qualifying tuple has to be overwritten by the next tuple, while the final tuple's pointer update, the done capture and the clearing of the pointers all land on one clock edge. Reaching this takes back-to-back streams in which misses sit between hits and the final tuple itself qualifies. The stimulus table does this by placing a miss at equality, a miss on the second term alone, and a qualifying final tuple. The bench keeps its own copy of the output memory, so it can confirm the compacted list once the scan is complete. The dual-lane run interleaves indices from both sides of the split point, so that each lane's pointer advances while the other lane is also active.

// File: rtl/sel_pkg.sv
package sel_pkg;
  typedef enum logic {LANE_LO = 1'b0, LANE_HI = 1'b1} lane_e;

  // lane choice for a tuple: upper lane only in dual mode at or above split
  function automatic lane_e pick_lane(input logic dual, input logic at_or_above);
    return (dual && at_or_above) ? LANE_HI : LANE_LO;
  endfunction
endpackage

// File: rtl/sel_pred_eval.sv
module sel_pred_eval #(
  parameter int NPRED = 2,
  parameter int FW    = 8
) (
  input  logic [NPRED*FW-1:0] fields,
  input  logic [NPRED*FW-1:0] thr,
  input  logic [NPRED-1:0]    en,
  output logic [NPRED-1:0]    term,
  output logic                hit
);
  function automatic logic term_ok(input logic [FW-1:0] f, input logic [FW-1:0] t,
                                   input logic e);
    return ~e | (f < t);
  endfunction

  for (genvar i = 0; i < NPRED; i++) begin : g_term
    assign term[i] = term_ok(fields[i*FW +: FW], thr[i*FW +: FW], en[i]);
  end

  // every term is always computed; plain AND, no early exit
  assign hit = &term;
endmodule

// File: rtl/sel_lane_ctr.sv
module sel_lane_ctr #(
  parameter int AW = 6,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          hit,
  input  logic          clear,
  output logic [AW-1:0] ptr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ptr <= '0;
      cnt <= '0;
    end else if (step) begin
      ptr <= ptr + AW'(hit);
      cnt <= cnt + CW'(hit);
    end
  end
endmodule

// File: rtl/sel_scan_top.sv
module sel_scan_top
  import sel_pkg::*;
#(
  parameter int NPRED = 2,
  parameter int FW    = 8,
  parameter int IW    = 8,
  parameter int AW    = 6,
  parameter int CW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dual_mode,
  input  logic [IW-1:0]       split_idx,
  input  logic [NPRED-1:0]    pred_en,
  input  logic [NPRED*FW-1:0] thr_vec,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [IW-1:0]       in_idx,
  input  logic [NPRED*FW-1:0] in_fields,
  input  logic                in_last,
  output logic                wr_en,
  output logic [AW-1:0]       wr_addr,
  output logic [IW-1:0]       wr_data,
  output logic [CW-1:0]       match_cnt,
  output logic                done,
  output logic [CW-1:0]       done_cnt
);
  localparam int NLANE = 2;
  localparam logic [AW-1:0] HI_BASE = AW'(1 << (AW - 1));

  logic [NPRED-1:0] term;
  logic             eval_hit;
  logic             accept;
  logic             rdy_q;

  // one-cycle stage holding the accepted tuple
  logic          s1_valid;
  logic [IW-1:0] s1_idx;
  logic          s1_hit;
  lane_e         s1_lane;
  logic          s1_last;

  logic [AW-1:0] lptr [NLANE];
  logic [CW-1:0] lcnt [NLANE];
  logic          scan_end;
  logic [CW-1:0] final_sum;

  sel_pred_eval #(.NPRED(NPRED), .FW(FW)) u_eval (
    .fields (in_fields),
    .thr    (thr_vec),
    .en     (pred_en),
    .term   (term),
    .hit    (eval_hit)
  );

  assign in_ready = rdy_q;
  assign accept   = in_valid & rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      s1_valid <= 1'b0;
      s1_idx   <= '0;
      s1_hit   <= 1'b0;
      s1_lane  <= LANE_LO;
      s1_last  <= 1'b0;
    end else begin
      rdy_q    <= 1'b1;
      s1_valid <= accept;
      s1_last  <= accept & in_last;
      if (accept) begin
        s1_idx  <= in_idx;
        s1_hit  <= eval_hit;
        s1_lane <= pick_lane(dual_mode, in_idx >= split_idx);
      end
    end
  end

  assign scan_end = s1_valid & s1_last;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    sel_lane_ctr #(.AW(AW), .CW(CW)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (s1_valid && (s1_lane == lane_e'(l))),
      .hit   (s1_hit),
      .clear (scan_end),
      .ptr   (lptr[l]),
      .cnt   (lcnt[l])
    );
  end

  // unconditional write of every staged tuple
  assign wr_en     = s1_valid;
  assign wr_data   = s1_idx;
  assign wr_addr   = (s1_lane == LANE_HI) ? HI_BASE + lptr[1] : lptr[0];
  assign match_cnt = lcnt[0] + lcnt[1];
  assign final_sum = match_cnt + CW'(s1_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      done_cnt <= '0;
    end else begin
      done <= scan_end;
      if (scan_end) done_cnt <= final_sum;
    end
  end
endmodule

// File: rtl/sel_scan_chk.sv
module sel_scan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          wr_en,
  input logic          s1_valid,
  input logic          s1_hit,
  input logic          s1_last,
  input logic [CW-1:0] match_cnt,
  input logic          done
);
  // R4
  write_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> wr_en);

  // R5
  no_write_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !wr_en);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_last) |=> (match_cnt == $past(match_cnt) + CW'($past(s1_hit))));

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(match_cnt));

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> ##1 done);

  // R7
  cleared_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (match_cnt == '0));
endmodule

bind sel_scan_top sel_scan_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .wr_en     (wr_en),
  .s1_valid  (s1_valid),
  .s1_hit    (s1_hit),
  .s1_last   (s1_last),
  .match_cnt (match_cnt),
  .done      (done)
);

// File: tb/tb_sel_scan_top.sv
module tb_sel_scan_top;
  localparam int NPRED = 2, FW = 8, IW = 8, AW = 6, CW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                rst_n = 1'b0;
  logic                dual_mode = 1'b0;
  logic [IW-1:0]       split_idx = '0;
  logic [NPRED-1:0]    pred_en = '0;
  logic [NPRED*FW-1:0] thr_vec = '0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [IW-1:0]       in_idx = '0;
  logic [NPRED*FW-1:0] in_fields = '0;
  logic                in_last = 1'b0;
  logic                wr_en;
  logic [AW-1:0]       wr_addr;
  logic [IW-1:0]       wr_data;
  logic [CW-1:0]       match_cnt;
  logic                done;
  logic [CW-1:0]       done_cnt;

  sel_scan_top #(.NPRED(NPRED), .FW(FW), .IW(IW), .AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .split_idx(split_idx),
    .pred_en(pred_en), .thr_vec(thr_vec), .in_valid(in_valid), .in_ready(in_ready),
    .in_idx(in_idx), .in_fields(in_fields), .in_last(in_last), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .match_cnt(match_cnt), .done(done),
    .done_cnt(done_cnt)
  );

  // bench copy of the output memory
  logic [IW-1:0] mem [64];
  always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

  int errs = 0, checks = 0;
  bit finished = 0;

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive a tuple at a falling edge, then check its write one cycle later
  task automatic beat(input int idx, input int f0, input int f1, input bit last,
                      input int exp_addr, input string req);
    in_valid  = 1'b1;
    in_idx    = IW'(idx);
    in_fields = {FW'(f1), FW'(f0)};
    in_last   = last;
    @(negedge clk);
    chk_eq(req, "wr_en", int'(wr_en), 1);
    chk_eq(req, "wr_addr", int'(wr_addr), exp_addr);
    chk_eq(req, "wr_data", int'(wr_data), idx);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  // table entry: {idx, f0, f1, last, expected hit}; thresholds 50 and 100
  localparam int NV = 6;
  localparam logic [25:0] VEC [NV] = '{
    {8'd3, 8'd10,  8'd20,  1'b0, 1'b1},
    {8'd4, 8'd50,  8'd20,  1'b0, 1'b0},
    {8'd5, 8'd49,  8'd99,  1'b0, 1'b1},
    {8'd6, 8'd49,  8'd100, 1'b0, 1'b0},
    {8'd7, 8'd200, 8'd200, 1'b0, 1'b0},
    {8'd8, 8'd0,   8'd0,   1'b1, 1'b1}
  };

  initial begin
    int exp_ptr;
    int exp_cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_eq("R1", "done in reset", int'(done), 0);
    chk_eq("R1", "wr_en in reset", int'(wr_en), 0);
    chk_eq("R1", "match_cnt in reset", int'(match_cnt), 0);
    chk_eq("R6", "ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R6", "ready after reset", int'(in_ready), 1);

    // R2 R4 R5 R9: table scan, back-to-back
    thr_vec = {8'd100, 8'd50};
    pred_en = 2'b11;
    exp_ptr = 0;
    exp_cnt = 0;
    for (int k = 0; k < NV; k++) begin
      beat(int'(VEC[k][25:18]), int'(VEC[k][17:10]), int'(VEC[k][9:2]), VEC[k][1],
           exp_ptr, "R2/R4");
      chk_eq("R5", "live count", int'(match_cnt), exp_cnt);
      exp_cnt += int'(VEC[k][0]);
      exp_ptr += int'(VEC[k][0]);
    end
    idle();
    @(negedge clk);
    chk_eq("R7", "done", int'(done), 1);
    chk_eq("R7", "done_cnt", int'(done_cnt), 3);
    chk_eq("R7", "cleared count", int'(match_cnt), 0);
    chk_eq("R5", "no write when idle", int'(wr_en), 0);
    chk_eq("R9", "slot0", int'(mem[0]), 3);
    chk_eq("R9", "slot1", int'(mem[1]), 5);
    chk_eq("R9", "slot2", int'(mem[2]), 8);
    @(negedge clk);
    chk_eq("R7", "done single pulse", int'(done), 0);

    // R5: idle gap inside a scan
    beat(20, 1, 1, 1'b0, 0, "R5");
    idle();
    @(negedge clk);
    chk_eq("R5", "gap wr_en", int'(wr_en), 0);
    chk_eq("R5", "gap count", int'(match_cnt), 1);
    @(negedge clk);
    chk_eq("R5", "gap count held", int'(match_cnt), 1);
    beat(21, 60, 1, 1'b0, 1, "R5");
    beat(22, 0, 0, 1'b1, 1, "R5");
    idle();
    @(negedge clk);
    chk_eq("R7", "done_cnt after gap", int'(done_cnt), 2);

    // R3: disabled terms are true
    pred_en = 2'b01;
    beat(30, 10, 255, 1'b0, 0, "R3");
    pred_en = 2'b00;
    beat(31, 255, 255, 1'b0, 1, "R3");
    beat(32, 255, 0, 1'b1, 2, "R3");
    idle();
    @(negedge clk);
    chk_eq("R3", "all disabled count", int'(done_cnt), 3);

    // R8: dual lanes split at index 8
    pred_en   = 2'b11;
    dual_mode = 1'b1;
    split_idx = 8'd8;
    beat(2, 1, 1, 1'b0, 0, "R8");
    beat(9, 1, 1, 1'b0, 32, "R8");
    beat(3, 99, 1, 1'b0, 1, "R8");
    chk_eq("R8", "sum of lanes", int'(match_cnt), 2);
    beat(10, 1, 1, 1'b1, 33, "R8");
    idle();
    @(negedge clk);
    chk_eq("R8", "done_cnt", int'(done_cnt), 3);
    chk_eq("R8", "upper slot", int'(mem[32]), 9);
    chk_eq("R8", "upper slot next", int'(mem[33]), 10);
    dual_mode = 1'b0;

    // R1: reset in the middle of a scan
    beat(40, 1, 1, 1'b0, 0, "R1");
    beat(41, 1, 1, 1'b0, 1, "R1");
    idle();
    @(negedge clk);
    chk_eq("R1", "count before reset", int'(match_cnt), 2);
    rst_n = 1'b0;
    @(negedge clk);
    chk_eq("R1", "count in reset", int'(match_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    beat(42, 1, 1, 1'b1, 0, "R1");
    idle();
    @(negedge clk);
    chk_eq("R1", "done_cnt after reset", int'(done_cnt), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule